// File: doc/BRIEF.md
# Control-Word Driven Register-File Datapath

This block is an 8-bit arithmetic datapath with no sequencing of its own. Each clock, an external controller presents one flat 20-bit horizontal control word. The word picks two register operands, the left-operand source, an ALU function, a single-step shift and the destination register. It also says whether the result appears on the output port. The datapath has an eight-entry register file with one write port and two combinational read ports. A selector chooses the left operand. The ALU computes one of eight functions and feeds a one-position shifter. The shifter result goes back to the write port and to a gated output.

A read port whose enable is low contributes zero. With port B disabled, "add" therefore copies the left operand into the destination register, and a controller can use it as a move.

Top module: `rf_datapath`

## Requirements
- R1: Control word fields, in bits: [19] input select (1 = external input is the left operand, 0 = read port A); [18:16] write address; [15] write enable; [14:12] read address A; [11] read enable A; [10:8] read address B; [7] read enable B; [6:4] ALU function; [3:1] shift function; [0] output enable.
- R2: ALU function codes, with L the left operand and B port B: 000 = ~L, 001 = L & B, 010 = L ^ B, 011 = L | B, 100 = L - 1, 101 = L + B, 110 = L - B, 111 = L + 1. All arithmetic wraps modulo 256.
- R3: Shift codes applied to the ALU result: 000, 001, 010 and 011 pass the value unchanged; 100 shifts left by one and fills a 0 into bit 0; 101 rotates left by one; 110 shifts right by one and fills a 0 into bit 7; 111 rotates right by one.
- R4: When input select is 1, the left operand is the external input. When it is 0, the left operand is read port A.
- R5: A read port whose enable is 0 supplies 0x00, whatever register its address names.
- R6: When write enable is 1, the shifter result is written into the addressed register on the rising clock edge. That value appears on the read ports from the next cycle. When write enable is 0, no register changes.
- R7: When output enable is 1, the output port shows the shifter result combinationally. When it is 0, the output port shows 0x00.
- R8: A synchronous active-high reset clears all eight registers to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 20 | Horizontal control word for this cycle |
| data_in | input | 8 | External operand |
| data_out | output | 8 | Gated shifter result |

## Verification
The bench builds the block with its default parameters: an 8-bit data width and eight registers, so all three address bits and the full ALU and shift code tables are reachable. At these values, a wrap from 0xFF to 0x00 comes up naturally. Every register index can also be filled and read back through port B, and the zero-fill on both shift edges is visible.

// File: rtl/rf_datapath_pkg.sv
package rf_datapath_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int CW = 20;

  typedef enum logic [2:0] {
    ALU_NOT = 3'b000, ALU_AND = 3'b001, ALU_XOR = 3'b010, ALU_OR  = 3'b011,
    ALU_DEC = 3'b100, ALU_ADD = 3'b101, ALU_SUB = 3'b110, ALU_INC = 3'b111
  } alu_fn_e;

  typedef enum logic [2:0] {
    SH_PASS0 = 3'b000, SH_PASS1 = 3'b001, SH_RSV0 = 3'b010, SH_RSV1 = 3'b011,
    SH_SLL   = 3'b100, SH_ROL   = 3'b101, SH_SRL  = 3'b110, SH_ROR  = 3'b111
  } sh_fn_e;

  typedef struct packed {
    logic          in_sel;
    logic [AW-1:0] wr_addr;
    logic          wr_en;
    logic [AW-1:0] ra_addr;
    logic          ra_en;
    logic [AW-1:0] rb_addr;
    logic          rb_en;
    alu_fn_e       alu_fn;
    sh_fn_e        sh_fn;
    logic          out_en;
  } ctrl_t;
endpackage

// File: rtl/rf_regfile.sv
module rf_regfile #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          ra_en,
  input  logic [AW-1:0] ra_addr,
  input  logic          rb_en,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] regs [DEPTH];
  logic          wr_fire;

  assign wr_fire = we && !rst;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)                                   regs[g] <= '0;
        else if (we && waddr == AW'(g))            regs[g] <= wdata;
      end
    end
  endgenerate

  assign ra_data = ra_en ? regs[ra_addr] : '0;
  assign rb_data = rb_en ? regs[rb_addr] : '0;

  // R5: a disabled port supplies zero
  a_r5_port_a_zero: assert property (@(posedge clk) disable iff (rst)
    !ra_en |-> ra_data == '0);
  a_r5_port_b_zero: assert property (@(posedge clk) disable iff (rst)
    !rb_en |-> rb_data == '0);
  // R6: a written value is readable on the next cycle
  a_r6_write_visible: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && ra_en && ra_addr == waddr) ##1 (ra_en && ra_addr == $past(waddr))
      |-> ra_data == $past(wdata));
  // R8: reset clears storage
  a_r8_reset_clear: assert property (@(posedge clk)
    $past(rst) && rb_en |-> rb_data == '0);
endmodule

// File: rtl/rf_alu.sv
module rf_alu
  import rf_datapath_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_fn_e       fn,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] res
);
  function automatic logic [DW-1:0] alu_eval(alu_fn_e f, logic [DW-1:0] a, logic [DW-1:0] b);
    unique case (f)
      ALU_NOT: return ~a;
      ALU_AND: return a & b;
      ALU_XOR: return a ^ b;
      ALU_OR:  return a | b;
      ALU_DEC: return a - DW'(1);
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      default: return a + DW'(1);
    endcase
  endfunction

  assign res = alu_eval(fn, lhs, rhs);

  // R2: add followed by subtract of the same operand is consistent
  always_comb begin
    if (fn == ALU_SUB) a_r2_sub_wrap: assert (DW'(res + rhs) == lhs);
    if (fn == ALU_INC) a_r2_inc_wrap: assert (DW'(res - DW'(1)) == lhs);
  end
endmodule

// File: rtl/rf_shifter.sv
module rf_shifter
  import rf_datapath_pkg::*;
#(
  parameter int DW = 8
) (
  input  sh_fn_e        fn,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  function automatic logic [DW-1:0] sh_eval(sh_fn_e f, logic [DW-1:0] v);
    case (f)
      SH_SLL:  return {v[DW-2:0], 1'b0};
      SH_ROL:  return {v[DW-2:0], v[DW-1]};
      SH_SRL:  return {1'b0, v[DW-1:1]};
      SH_ROR:  return {v[0], v[DW-1:1]};
      default: return v;
    endcase
  endfunction

  assign dout = sh_eval(fn, din);

  // R3: rotations keep the bit count, plain shifts zero-fill
  always_comb begin
    if (fn == SH_ROL || fn == SH_ROR) a_r3_rot_bits: assert ($countones(dout) == $countones(din));
    if (fn == SH_SLL) a_r3_sll_fill: assert (dout[0] == 1'b0);
    if (fn == SH_SRL) a_r3_srl_fill: assert (dout[DW-1] == 1'b0);
  end
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_datapath_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ctrl_word,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out
);
  ctrl_t         cw;
  logic [DW-1:0] bus_a, bus_b, lhs, alu_res, sh_res;

  assign cw = ctrl_t'(ctrl_word);

  rf_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk(clk), .rst(rst),
    .we(cw.wr_en), .waddr(cw.wr_addr), .wdata(sh_res),
    .ra_en(cw.ra_en), .ra_addr(cw.ra_addr),
    .rb_en(cw.rb_en), .rb_addr(cw.rb_addr),
    .ra_data(bus_a), .rb_data(bus_b)
  );

  assign lhs = cw.in_sel ? data_in : bus_a;

  rf_alu #(.DW(DW)) u_alu (.fn(cw.alu_fn), .lhs(lhs), .rhs(bus_b), .res(alu_res));
  rf_shifter #(.DW(DW)) u_sh (.fn(cw.sh_fn), .din(alu_res), .dout(sh_res));

  assign data_out = cw.out_en ? sh_res : '0;

  // R7: gated output is zero when disabled
  a_r7_out_gate: assert property (@(posedge clk) disable iff (rst)
    !ctrl_word[0] |-> data_out == '0);
  // R4: external input selected with pass/or-zero path reaches output
  a_r4_in_sel: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[19] && !ctrl_word[7] && ctrl_word[6:4] == 3'b011 &&
     ctrl_word[3:1] == 3'b000 && ctrl_word[0]) |-> data_out == data_in);
endmodule

// File: tb/rf_datapath_tb_top.sv
module rf_datapath_tb_top;
  logic        clk = 0;
  logic        rst;
  logic [19:0] ctrl_word;
  logic [7:0]  data_in;
  logic [7:0]  data_out;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rf_datapath dut_i (.clk(clk), .rst(rst), .ctrl_word(ctrl_word),
                     .data_in(data_in), .data_out(data_out));

  function automatic logic [19:0] mk(bit ie, int wa, bit we, int ra, bit rae,
                                     int rb, bit rbe, int alu, int sh, bit oe);
    return {ie, 3'(wa), we, 3'(ra), rae, 3'(rb), rbe, 3'(alu), 3'(sh), oe};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // apply a word, sample mid-cycle, then take the edge
  task automatic step(logic [19:0] w, logic [7:0] d);
    ctrl_word = w; data_in = d;
    @(posedge clk); #1;
  endtask

  task automatic load(int r, logic [7:0] v);
    step(mk(1, r, 1, 0, 0, 0, 0, 5, 0, 0), v);
  endtask

  // read register r through port B (left operand zero via disabled port A, OR)
  task automatic peek(string req, int r, logic [7:0] exp);
    ctrl_word = mk(0, 0, 0, 0, 0, r, 1, 3, 0, 1); data_in = 8'hFF;
    #1 chk(req, data_out, exp);
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    for (int r = 0; r < 8; r++) peek("R8", r, 8'h00);
  endtask

  task automatic t_regs;
    for (int r = 0; r < 8; r++) load(r, 8'(8'h11 * (r + 1)));
    for (int r = 0; r < 8; r++) peek("R6", r, 8'(8'h11 * (r + 1)));
    // write disabled: no change
    step(mk(1, 2, 0, 0, 0, 0, 0, 5, 0, 0), 8'hAB);
    peek("R6", 2, 8'h33);
  endtask

  task automatic t_alu;
    logic [7:0] a = 8'hC5, b = 8'h3A;
    logic [7:0] e [8];
    e[0] = 8'h3A; e[1] = 8'h00; e[2] = 8'hFF; e[3] = 8'hFF;
    e[4] = 8'hC4; e[5] = 8'hFF; e[6] = 8'h8B; e[7] = 8'hC6;
    load(1, a); load(2, b);
    for (int f = 0; f < 8; f++) begin
      ctrl_word = mk(0, 0, 0, 1, 1, 2, 1, f, 0, 1); #1;
      chk("R2", data_out, e[f]);
      @(posedge clk); #1;
    end
    // wrap cases
    ctrl_word = mk(1, 0, 0, 0, 0, 0, 0, 7, 0, 1); data_in = 8'hFF; #1;
    chk("R2", data_out, 8'h00);
    ctrl_word = mk(1, 0, 0, 0, 0, 0, 0, 4, 0, 1); data_in = 8'h00; #1;
    chk("R2", data_out, 8'hFF);
    @(posedge clk); #1;
  endtask

  task automatic t_shift;
    logic [7:0] v = 8'b1001_0110;
    logic [7:0] e [8];
    e[0] = v; e[1] = v; e[2] = v; e[3] = v;
    e[4] = 8'b0010_1100; e[5] = 8'b0010_1101;
    e[6] = 8'b0100_1011; e[7] = 8'b0100_1011;
    for (int s = 0; s < 8; s++) begin
      ctrl_word = mk(1, 0, 0, 0, 0, 0, 0, 5, s, 1); data_in = v; #1;
      chk("R3", data_out, e[s]);
    end
    ctrl_word = mk(1, 0, 0, 0, 0, 0, 0, 5, 7, 1); data_in = 8'h81; #1;
    chk("R3", data_out, 8'hC0);
    ctrl_word = mk(1, 0, 0, 0, 0, 0, 0, 5, 6, 1); #1;
    chk("R3", data_out, 8'h40);
    // shifted result written back
    step(mk(1, 5, 1, 0, 0, 0, 0, 5, 4, 0), 8'h81);
    peek("R3", 5, 8'h02);
    @(posedge clk); #1;
  endtask

  task automatic t_sel_zero;
    load(3, 8'h55);
    // input select 1 ignores port A
    ctrl_word = mk(1, 0, 0, 3, 1, 0, 0, 5, 0, 1); data_in = 8'h0F; #1;
    chk("R4", data_out, 8'h0F);
    ctrl_word = mk(0, 0, 0, 3, 1, 0, 0, 5, 0, 1); #1;
    chk("R4", data_out, 8'h55);
    // disabled ports read zero even when addressing a loaded register
    ctrl_word = mk(0, 0, 0, 3, 0, 3, 0, 3, 0, 1); #1;
    chk("R5", data_out, 8'h00);
    // move: add with port B disabled
    step(mk(0, 6, 1, 3, 1, 3, 0, 5, 0, 0), 8'h00);
    peek("R5", 6, 8'h55);
  endtask

  task automatic t_out_gate;
    ctrl_word = mk(1, 0, 0, 0, 0, 0, 0, 5, 0, 0); data_in = 8'hA7; #1;
    chk("R7", data_out, 8'h00);
    ctrl_word[0] = 1'b1; #1;
    chk("R7", data_out, 8'hA7);
    // field layout: write addr bits land in the right register (R1)
    step(mk(1, 4, 1, 0, 0, 0, 0, 5, 0, 0), 8'h3C);
    peek("R1", 4, 8'h3C);
    peek("R1", 0, 8'h11);
  endtask

  initial begin
    rst = 1; ctrl_word = '0; data_in = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_regs();
    t_alu();
    t_shift();
    t_sel_zero();
    t_out_gate();
    // reset clears again
    rst = 1; @(posedge clk); #1; rst = 0;
    peek("R8", 1, 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule